// File: doc/BRIEF.md
# Shifter Operand Unit

This block produces the second ALU operand of a 32-bit RISC datapath and the carry that the shifter hands to the flag logic. It works in one of two modes. In immediate mode a 12-bit field is turned into a 32-bit constant: the low eight bits are zero-extended and then rotated right by twice the value in the top four bits. In register mode a register value goes through one of five shift kinds. The amount comes from a 5-bit immediate or from the low byte of a second register. The register value is only read and is never modified.

Each operation is a single stream item. The item enters on a valid/ready pair and leaves one cycle later through an output register that also uses valid/ready. Rules for back-pressure: `in_ready` is high when the output register is empty or is being drained in the same cycle. An item is taken on a clock edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, `operand` and `carry_out` stay frozen. No item is dropped and none is repeated. Items leave in the order they arrived.

Top module: `sop_operand_unit`

## Requirements
- R1: With `use_imm`=1, `operand` equals `imm_field[7:0]` zero-extended to 32 bits and rotated right by 2*`imm_field[11:8]` positions.
- R2: In immediate mode, `carry_out` is `operand[31]` when `imm_field[11:8]` is nonzero and `carry_in` otherwise. In this mode `rm_val`, `shift_kind`, `amt_from_reg`, `amt_imm` and `rs_val` have no effect.
- R3: `shift_kind` codes 0 (logical left), 1 (arithmetic left) and the unused codes 6 and 7 all behave the same. For an amount n from 1 to 31 the result is `rm_val` shifted left by n with zero fill, and `carry_out` is `rm_val[32-n]`.
- R4: Code 2 (logical right), for n from 1 to 31, shifts right with zero fill. `carry_out` is `rm_val[n-1]`.
- R5: Code 3 (arithmetic right), for n from 1 to 31, shifts right and fills the vacated bits with `rm_val[31]`. `carry_out` is `rm_val[n-1]`.
- R6: Code 4 (rotate right) rotates by n mod 32, and `carry_out` is bit 31 of the result. A nonzero n that is a multiple of 32 leaves the value unchanged, with `carry_out` = `rm_val[31]`.
- R7: Code 5 (rotate right extended) gives {`carry_in`, `rm_val[31:1]`} with `carry_out` = `rm_val[0]`, whatever the amount inputs are.
- R8: For every code except 5, a shift amount of zero passes `rm_val` through unchanged and gives `carry_out` = `carry_in`.
- R9: When `amt_from_reg`=1, the amount is `rs_val[7:0]` and `rs_val[31:8]` is ignored. With that amount:
  - Logical shifts by exactly 32 give zero, with carry `rm_val[0]` (left) or `rm_val[31]` (right).
  - Logical shifts by more than 32 give zero with carry 0.
  - Arithmetic right shifts by 32 or more give 32 copies of `rm_val[31]`, with that bit as the carry.
- R10: After reset `out_valid` is 0 and `in_ready` is 1. An item taken at one edge shows up on the output with `out_valid` after that edge. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. The output holds stable while it is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can take an item this cycle |
| use_imm | input | 1 | 1: immediate mode, 0: register mode |
| imm_field | input | 12 | [11:8] rotate count, [7:0] constant |
| rm_val | input | 32 | Value to be shifted |
| shift_kind | input | 3 | Shift code (see R3 to R7) |
| amt_from_reg | input | 1 | 1: amount from `rs_val[7:0]`, 0: from `amt_imm` |
| amt_imm | input | 5 | Immediate shift amount |
| rs_val | input | 32 | Register holding the shift amount |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Two things can happen in the same cycle. The output register hands a finished result to the consumer, and it also captures the next item from the producer. The bench provokes this with back-to-back items while `out_ready` follows an irregular pattern, so drains, stalls and captures overlap on the same edges. A queue of reference results judges every output in order, which catches any lost, duplicated or reordered result. A separate check confirms that a stalled result stays unchanged until it is taken.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_ASL = 3'd1,
    SK_LSR = 3'd2,
    SK_ASR = 3'd3,
    SK_ROR = 3'd4,
    SK_RRX = 3'd5
  } shift_kind_e;
endpackage

// File: rtl/sop_imm_expand.sv
module sop_imm_expand #(
  parameter int DATA_W  = 32,
  parameter int CONST_W = 8,
  parameter int ROT_W   = 4
) (
  input  logic [CONST_W-1:0] konst,
  input  logic [ROT_W-1:0]   rot,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  value,
  output logic               carry_out
);
  localparam int NROT = 1 << ROT_W;

  logic [DATA_W-1:0]   base;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   cand [NROT];

  assign base = {{(DATA_W-CONST_W){1'b0}}, konst};
  assign dbl  = {base, base};

  // one candidate per rotate code; rotate right by 2*r
  for (genvar r = 0; r < NROT; r++) begin : g_rot
    localparam int SH = (2 * r) % DATA_W;
    assign cand[r] = dbl[SH +: DATA_W];
  end

  assign value     = cand[rot];
  assign carry_out = (rot != '0) ? value[DATA_W-1] : carry_in;
endmodule

// File: rtl/sop_shifter.sv
module sop_shifter
  import sop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value,
  input  logic [2:0]        kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int LOG_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [LOG_W-1:0]    sh;
  logic                is_zero, is_full, is_over;
  logic [DATA_W:0]     t_left, t_right;
  logic signed [DATA_W:0] t_arith;
  logic [2*DATA_W-1:0] t_rot;

  assign sh      = amount[LOG_W-1:0];
  assign is_zero = (amount == '0);
  assign is_full = (amount == FULL);
  assign is_over = (amount > FULL);

  always_comb begin
    t_left    = {1'b0, value} << sh;
    t_right   = {value, 1'b0} >> sh;
    t_arith   = $signed({value, 1'b0}) >>> sh;
    t_rot     = {value, value} >> sh;
    result    = value;
    carry_out = carry_in;
    case (shift_kind_e'(kind))
      SK_RRX: begin
        result    = {carry_in, value[DATA_W-1:1]};
        carry_out = value[0];
      end
      SK_LSR: begin
        if (is_zero) begin
          result    = value;
          carry_out = carry_in;
        end else if (is_full) begin
          result    = '0;
          carry_out = value[DATA_W-1];
        end else if (is_over) begin
          result    = '0;
          carry_out = 1'b0;
        end else begin
          result    = t_right[DATA_W:1];
          carry_out = t_right[0];
        end
      end
      SK_ASR: begin
        if (is_zero) begin
          result    = value;
          carry_out = carry_in;
        end else if (is_full || is_over) begin
          result    = {DATA_W{value[DATA_W-1]}};
          carry_out = value[DATA_W-1];
        end else begin
          result    = t_arith[DATA_W:1];
          carry_out = t_arith[0];
        end
      end
      SK_ROR: begin
        if (is_zero) begin
          result    = value;
          carry_out = carry_in;
        end else if (sh == '0) begin
          result    = value;
          carry_out = value[DATA_W-1];
        end else begin
          result    = t_rot[DATA_W-1:0];
          carry_out = t_rot[DATA_W-1];
        end
      end
      default: begin
        if (is_zero) begin
          result    = value;
          carry_out = carry_in;
        end else if (is_full) begin
          result    = '0;
          carry_out = value[0];
        end else if (is_over) begin
          result    = '0;
          carry_out = 1'b0;
        end else begin
          result    = t_left[DATA_W-1:0];
          carry_out = t_left[DATA_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (take) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/sop_operand_unit.sv
module sop_operand_unit #(
  parameter int DATA_W      = 32,
  parameter int IMM_CONST_W = 8,
  parameter int IMM_ROT_W   = 4,
  parameter int SHAMT_W     = 5,
  parameter int REG_AMT_W   = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic                               use_imm,
  input  logic [IMM_CONST_W+IMM_ROT_W-1:0]   imm_field,
  input  logic [DATA_W-1:0]                  rm_val,
  input  logic [2:0]                         shift_kind,
  input  logic                               amt_from_reg,
  input  logic [SHAMT_W-1:0]                 amt_imm,
  input  logic [DATA_W-1:0]                  rs_val,
  input  logic                               carry_in,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [DATA_W-1:0]                  operand,
  output logic                               carry_out
);
  localparam int IMM_W = IMM_CONST_W + IMM_ROT_W;
  localparam int PKT_W = DATA_W + 1;

  logic [DATA_W-1:0]    imm_val, sh_val, sel_val;
  logic                 imm_c, sh_c, sel_c;
  logic [REG_AMT_W-1:0] amount;
  logic [PKT_W-1:0]     pkt_out;

  assign amount = amt_from_reg ? rs_val[REG_AMT_W-1:0]
                               : {{(REG_AMT_W-SHAMT_W){1'b0}}, amt_imm};

  sop_imm_expand #(
    .DATA_W (DATA_W),
    .CONST_W(IMM_CONST_W),
    .ROT_W  (IMM_ROT_W)
  ) u_imm (
    .konst    (imm_field[IMM_CONST_W-1:0]),
    .rot      (imm_field[IMM_W-1:IMM_CONST_W]),
    .carry_in (carry_in),
    .value    (imm_val),
    .carry_out(imm_c)
  );

  sop_shifter #(
    .DATA_W(DATA_W),
    .AMT_W (REG_AMT_W)
  ) u_shift (
    .value    (rm_val),
    .kind     (shift_kind),
    .amount   (amount),
    .carry_in (carry_in),
    .result   (sh_val),
    .carry_out(sh_c)
  );

  assign sel_val = use_imm ? imm_val : sh_val;
  assign sel_c   = use_imm ? imm_c   : sh_c;

  sop_out_stage #(.W(PKT_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({sel_c, sel_val}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (pkt_out)
  );

  assign operand   = pkt_out[DATA_W-1:0];
  assign carry_out = pkt_out[DATA_W];
endmodule

// File: rtl/sop_operand_unit_chk.sv
module sop_operand_unit_chk #(
  parameter int DATA_W      = 32,
  parameter int IMM_CONST_W = 8,
  parameter int IMM_ROT_W   = 4,
  parameter int SHAMT_W     = 5,
  parameter int REG_AMT_W   = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             in_valid,
  input logic                             in_ready,
  input logic                             use_imm,
  input logic [IMM_CONST_W+IMM_ROT_W-1:0] imm_field,
  input logic [DATA_W-1:0]                rm_val,
  input logic [2:0]                       shift_kind,
  input logic                             amt_from_reg,
  input logic [SHAMT_W-1:0]               amt_imm,
  input logic [DATA_W-1:0]                rs_val,
  input logic                             carry_in,
  input logic                             out_valid,
  input logic                             out_ready,
  input logic [DATA_W-1:0]                operand,
  input logic                             carry_out
);
  localparam int IMM_W = IMM_CONST_W + IMM_ROT_W;

  logic fire, zero_amt;
  assign fire     = in_valid && in_ready;
  assign zero_amt = amt_from_reg ? (rs_val[REG_AMT_W-1:0] == '0) : (amt_imm == '0);

  // R10: accepted item appears on the output next cycle
  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R10: stalled result is held
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(operand) && $stable(carry_out)));

  // R1 / R2: unrotated immediate is the zero-extended constant, carry from input
  assert_imm_norot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && use_imm && imm_field[IMM_W-1:IMM_CONST_W] == '0) |=>
      (operand[IMM_CONST_W-1:0] == $past(imm_field[IMM_CONST_W-1:0]) &&
       operand[DATA_W-1:IMM_CONST_W] == '0 && carry_out == $past(carry_in)));

  // R7: rotate through carry
  assert_rrx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !use_imm && shift_kind == 3'd5) |=>
      (operand == {$past(carry_in), $past(rm_val[DATA_W-1:1])} && carry_out == $past(rm_val[0])));

  // R8: zero amount passes the value and the carry through
  assert_zero_amt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !use_imm && shift_kind != 3'd5 && zero_amt) |=>
      (operand == $past(rm_val) && carry_out == $past(carry_in)));
endmodule

bind sop_operand_unit sop_operand_unit_chk #(
  .DATA_W     (DATA_W),
  .IMM_CONST_W(IMM_CONST_W),
  .IMM_ROT_W  (IMM_ROT_W),
  .SHAMT_W    (SHAMT_W),
  .REG_AMT_W  (REG_AMT_W)
) u_chk (.*);

// File: tb/sop_operand_unit_tb.sv
`timescale 1ns/1ps
module sop_operand_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        use_imm = 1'b0;
  logic [11:0] imm_field = '0;
  logic [31:0] rm_val = '0;
  logic [2:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  amt_imm = '0;
  logic [31:0] rs_val = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] operand;
  logic        carry_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ready_mode = 1'b0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic [32:0] held;
  bit          hold_armed = 1'b0;

  always #2 clk = ~clk;

  sop_operand_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .use_imm(use_imm), .imm_field(imm_field), .rm_val(rm_val),
    .shift_kind(shift_kind), .amt_from_reg(amt_from_reg), .amt_imm(amt_imm),
    .rs_val(rs_val), .carry_in(carry_in), .out_valid(out_valid),
    .out_ready(out_ready), .operand(operand), .carry_out(carry_out)
  );

  task automatic report(input string tag, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: bit-at-a-time model built from the requirements
  function automatic logic [32:0] model(input logic ui, input logic [11:0] imm,
      input logic [31:0] rm, input logic [2:0] k, input logic fr,
      input logic [4:0] ai, input logic [31:0] rs, input logic ci);
    logic [31:0] v;
    logic c;
    int n;
    if (ui) begin
      v = {24'h0, imm[7:0]};
      c = ci;
      for (int i = 0; i < 2 * int'(imm[11:8]); i++) v = {v[0], v[31:1]};
      if (imm[11:8] != 4'd0) c = v[31];
      return {c, v};
    end
    if (k == 3'd5) return {rm[0], ci, rm[31:1]};
    v = rm;
    c = ci;
    n = fr ? int'(rs[7:0]) : int'(ai);
    case (k)
      3'd2: for (int i = 0; i < n; i++) begin c = v[0]; v = v >> 1; end
      3'd3: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
      3'd4: if (n != 0) begin
        for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
        if (n % 32 == 0) c = v[31];
      end
      default: for (int i = 0; i < n; i++) begin c = v[31]; v = v << 1; end
    endcase
    return {c, v};
  endfunction

  // driver: called just after a rising edge
  task automatic send(input logic ui, input logic [11:0] imm, input logic [31:0] rm,
      input logic [2:0] k, input logic fr, input logic [4:0] ai,
      input logic [31:0] rs, input logic ci, input string tag);
    bit accepted = 1'b0;
    bit rdy;
    use_imm = ui; imm_field = imm; rm_val = rm; shift_kind = k;
    amt_from_reg = fr; amt_imm = ai; rs_val = rs; carry_in = ci;
    in_valid = 1'b1;
    while (!accepted) begin
      @(negedge clk);
      rdy = in_ready;
      @(posedge clk);
      #1;
      if (rdy) accepted = 1'b1;
    end
    exp_q.push_back(model(ui, imm, rm, k, fr, ai, rs, ci));
    tag_q.push_back(tag);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    out_ready <= ready_mode ? ((cyc % 5) != 2 && (cyc % 7) != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      report("R10 reset state", {31'd0, out_valid, in_ready}, 33'd1);
    end else begin
      if (hold_armed) begin
        report("R10 stall hold", {carry_out, operand}, held);
        hold_armed = 1'b0;
      end
      if (out_valid && !out_ready) begin
        held = {carry_out, operand};
        hold_armed = 1'b1;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R10 unexpected output actual=%h expected=none", {carry_out, operand});
        end else begin
          report(tag_q.pop_front(), {carry_out, operand}, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 / R2 immediate
    send(1, 12'h0FF, 32'h0, 3'd0, 0, 5'd0, 32'h0, 1'b0, "R1 imm no rotate");
    send(1, 12'h4FF, 32'hDEAD, 3'd5, 1, 5'd7, 32'h3, 1'b0, "R1 imm rotate 8");
    send(1, 12'hF81, 32'h0, 3'd0, 0, 5'd0, 32'h0, 1'b0, "R1 imm rotate 30");
    send(1, 12'h0A5, 32'hFFFF_FFFF, 3'd5, 1, 5'd9, 32'hFF, 1'b1, "R2 imm carry kept, fields ignored");
    send(1, 12'h17F, 32'h1234, 3'd2, 0, 5'd3, 32'h0, 1'b1, "R2 imm carry from bit31");
    // R3 left
    send(0, 12'h0, 32'h8000_0001, 3'd0, 0, 5'd4, 32'h0, 1'b1, "R3 lsl 4");
    send(0, 12'h0, 32'h8000_0001, 3'd1, 0, 5'd4, 32'h0, 1'b1, "R3 asl equals lsl");
    send(0, 12'h0, 32'h8000_0000, 3'd6, 0, 5'd1, 32'h0, 1'b0, "R3 code 6 as lsl");
    send(0, 12'h0, 32'h0000_0003, 3'd7, 0, 5'd31, 32'h0, 1'b0, "R3 code 7 lsl 31");
    // R4 / R5 right
    send(0, 12'h0, 32'h0000_0003, 3'd2, 0, 5'd1, 32'h0, 1'b0, "R4 lsr 1");
    send(0, 12'h0, 32'h8000_0000, 3'd2, 0, 5'd31, 32'h0, 1'b1, "R4 lsr 31");
    send(0, 12'h0, 32'h8000_0018, 3'd3, 0, 5'd4, 32'h0, 1'b0, "R5 asr negative");
    send(0, 12'h0, 32'h7000_0018, 3'd3, 0, 5'd4, 32'h0, 1'b1, "R5 asr positive");
    // R6 rotate
    send(0, 12'h0, 32'h1234_5678, 3'd4, 0, 5'd8, 32'h0, 1'b1, "R6 ror 8");
    send(0, 12'h0, 32'h1234_5678, 3'd4, 1, 5'd0, 32'd40, 1'b0, "R6 ror by 40");
    send(0, 12'h0, 32'h9234_5678, 3'd4, 1, 5'd0, 32'd64, 1'b0, "R6 ror by 64");
    // R7 extended rotate
    send(0, 12'h0, 32'h0000_0001, 3'd5, 0, 5'd17, 32'h0, 1'b1, "R7 rrx carry in 1");
    send(0, 12'h0, 32'hF000_0002, 3'd5, 1, 5'd0, 32'd9, 1'b0, "R7 rrx carry in 0");
    // R8 zero amount
    send(0, 12'h0, 32'hCAFE_F00D, 3'd2, 0, 5'd0, 32'h0, 1'b1, "R8 zero imm amount");
    send(0, 12'h0, 32'hCAFE_F00D, 3'd3, 1, 5'd5, 32'h0000_0100, 1'b0, "R8 zero reg amount");
    send(0, 12'h0, 32'hCAFE_F00D, 3'd4, 0, 5'd0, 32'h0, 1'b1, "R8 zero ror amount");
    // R9 register amounts
    send(0, 12'h0, 32'h0000_0001, 3'd0, 1, 5'd0, 32'd32, 1'b0, "R9 lsl by 32");
    send(0, 12'h0, 32'hFFFF_FFFF, 3'd0, 1, 5'd0, 32'd33, 1'b1, "R9 lsl by 33");
    send(0, 12'h0, 32'h8000_0000, 3'd2, 1, 5'd0, 32'd32, 1'b0, "R9 lsr by 32");
    send(0, 12'h0, 32'hFFFF_FFFF, 3'd2, 1, 5'd0, 32'd200, 1'b1, "R9 lsr by 200");
    send(0, 12'h0, 32'h8000_0001, 3'd3, 1, 5'd0, 32'd200, 1'b0, "R9 asr by 200");
    send(0, 12'h0, 32'h4000_0001, 3'd3, 1, 5'd0, 32'd32, 1'b1, "R9 asr by 32 positive");
    send(0, 12'h0, 32'h0000_00F0, 3'd2, 1, 5'd0, 32'hFFFF_FF05, 1'b0, "R9 upper rs bits ignored");
    // mixed traffic, first free-flowing, then with back-pressure
    for (int pass = 0; pass < 2; pass++) begin
      ready_mode = (pass == 1);
      for (int i = 0; i < 300; i++) begin
        logic [31:0] r0, r1, r2;
        r0 = $urandom; r1 = $urandom; r2 = $urandom;
        send(r0[0], r1[11:0], r2, r0[3:1], r0[4], r0[9:5],
             (r0[10] ? {r1[31:8], 8'(r0[18:11] & 8'h3F)} : r1), r0[19],
             pass == 0 ? "R10 mixed stream" : "R10 mixed stream with back-pressure");
      end
    end
    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(posedge clk);
    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R10 results missing actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule